// File: doc/BRIEF.md
# Input Sample Rate Path Selector

This block sits in front of a sample rate converter whose output is always a 48 kHz stream. It decides whether the incoming audio needs an extra x2 interpolation stage before the anti-alias filter. It makes that choice by measuring the frame rate of the incoming word clock in the 49.152 MHz reference domain. The word clock is asynchronous to that domain, so it first passes through a two-flop synchronizer. The block then counts its rising edges over a fixed gate of reference cycles. With the default gate of 491,520 cycles (10 ms), one count equals 100 Hz.

Each finished gate yields a measurement. That measurement goes to the rate output and is checked against the previous one. When three measurements in a row agree within one count, the block declares lock. Only while locked does the block compare the rate with the threshold input. The comparison uses a fixed hysteresis band of five counts (500 Hz) on each side of the threshold. The path select output switches only when the rate leaves that band, and otherwise keeps its value.

Top module: `rate_path_selector`

## Requirements
- R1: While reset is active, the rate output is 0, the lock flag is 0 and the path select is 1 (x2 interpolation path).
- R2: At the end of each gate of GATE_CYCLES reference cycles, the rate output is set to the number of word clock rising edges seen during that gate. For a steady word clock with a period of P reference cycles, where P divides GATE_CYCLES, the value is GATE_CYCLES/P.
- R3: The lock flag rises at the end of the third consecutive gate whose measurement is within ±1 count of the measurement of the gate before it.
- R4: At the end of a gate whose measurement differs from the previous measurement by more than one count, the lock flag drops to 0 and the agreement run restarts.
- R5: At the end of a gate in which no word clock rising edge was seen, the rate output is 0 and the lock flag is 0.
- R6: While locked, the path select becomes 0 (direct anti-alias path) at a gate end where the measured rate is greater than the threshold plus HYST_COUNTS.
- R7: While locked, the path select becomes 1 (x2 path) at a gate end where the measured rate plus HYST_COUNTS is less than the threshold.
- R8: While locked, a rate that lies inside the band from threshold minus HYST_COUNTS to threshold plus HYST_COUNTS (both inclusive) leaves the path select unchanged.
- R9: The path select never changes while the lock flag is 0. It keeps the last value it had before lock was lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock (nominally 49.152 MHz) |
| rstN | input | 1 | Asynchronous active-low reset |
| lrckIn | input | 1 | Incoming word clock, asynchronous to clk |
| thresholdIn | input | RATE_W | Switch-over threshold in rate counts; sampled at each gate end |
| rateOut | output | RATE_W | Last gate measurement in rate counts (100 Hz per count by default) |
| lockOut | output | 1 | High once the measurement has settled |
| selectX2Out | output | 1 | 1 = insert x2 interpolation, 0 = direct anti-alias path |

## Verification
The assertions check four rules on every cycle. The select changes only while locked. A fall of the select always comes with a rate above the upper band edge, and a rise always comes with a rate below the lower band edge. Lock rises only on a measurement within one count of the one before it, and a zero rate never coexists with lock. Some behaviours can only be shown by the bench scenarios. These are the exact edge count per gate for several word clock periods, the three-gate delay before lock, and the loss of lock after a rate jump or a stopped clock. The bench also sweeps the threshold up and then down across a steady rate, which shows that the select holds inside the band.

// File: rtl/ratesel_pkg.sv
package ratesel_pkg;
  // strobes issued by the gate controller to the datapath
  typedef struct packed {
    logic gateEnd;    // last reference cycle of the measurement gate
    logic selUpdate;  // re-evaluate the path select this cycle
  } ctrlStrobe_t;

  // per-gate measurement flags returned by the datapath
  typedef struct packed {
    logic agree;   // within one count of previous gate
    logic silent;  // no edge seen in this gate
  } measFlags_t;
endpackage

// File: rtl/ratesel_datapath.sv
module ratesel_datapath
  import ratesel_pkg::*;
#(
  parameter int RATE_W      = 16,
  parameter int HYST_COUNTS = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lrckIn,
  input  logic [RATE_W-1:0] thresholdIn,
  input  ctrlStrobe_t       strobe,
  output measFlags_t        flags,
  output logic [RATE_W-1:0] rateOut,
  output logic              selectX2Out
);
  localparam logic [RATE_W-1:0] CNT_MAX = '1;
  localparam logic [RATE_W:0]   HYST_W  = (RATE_W+1)'(HYST_COUNTS);

  logic              syncA, syncB, syncPrev;
  logic              riseDet;
  logic [RATE_W-1:0] edgeCnt, measNow, rateReg, absDiff;
  logic              selReg;

  // two-flop synchronizer plus a history flop for edge detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA    <= 1'b0;
      syncB    <= 1'b0;
      syncPrev <= 1'b0;
    end else begin
      syncA    <= lrckIn;
      syncB    <= syncA;
      syncPrev <= syncB;
    end
  end

  assign riseDet = syncB & ~syncPrev;

  // count including an edge that lands on the final gate cycle
  always_comb begin
    if (riseDet && edgeCnt != CNT_MAX) measNow = edgeCnt + 1'b1;
    else                               measNow = edgeCnt;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      edgeCnt <= '0;
      rateReg <= '0;
    end else if (strobe.gateEnd) begin
      edgeCnt <= '0;
      rateReg <= measNow;
    end else if (riseDet && edgeCnt != CNT_MAX) begin
      edgeCnt <= edgeCnt + 1'b1;
    end
  end

  always_comb begin
    absDiff      = (measNow >= rateReg) ? (measNow - rateReg) : (rateReg - measNow);
    flags.agree  = (absDiff <= RATE_W'(1));
    flags.silent = (measNow == '0);
  end

  // hysteresis comparison, widened by one bit against overflow
  logic [RATE_W:0] measWide, thrWide;
  assign measWide = {1'b0, measNow};
  assign thrWide  = {1'b0, thresholdIn};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selReg <= 1'b1;
    end else if (strobe.selUpdate) begin
      if (measWide > thrWide + HYST_W)       selReg <= 1'b0;
      else if (measWide + HYST_W < thrWide)  selReg <= 1'b1;
    end
  end

  assign rateOut     = rateReg;
  assign selectX2Out = selReg;
endmodule

// File: rtl/ratesel_control.sv
module ratesel_control
  import ratesel_pkg::*;
#(
  parameter int GATE_CYCLES = 491520,
  parameter int LOCK_RUN    = 3
) (
  input  logic        clk,
  input  logic        rstN,
  input  measFlags_t  flags,
  output ctrlStrobe_t strobe,
  output logic        lockOut
);
  localparam int GW = (GATE_CYCLES > 1) ? $clog2(GATE_CYCLES) : 1;
  localparam int SW = $clog2(LOCK_RUN + 1);
  localparam logic [GW-1:0] GATE_LAST = GW'(GATE_CYCLES - 1);
  localparam logic [SW-1:0] RUN_FULL  = SW'(LOCK_RUN);

  logic [GW-1:0] gateCnt;
  logic [SW-1:0] streak, streakNext;
  logic          gateEnd, lockNext, lockReg;

  assign gateEnd = (gateCnt == GATE_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        gateCnt <= '0;
    else if (gateEnd) gateCnt <= '0;
    else              gateCnt <= gateCnt + 1'b1;
  end

  // length of the current run of agreeing measurements
  always_comb begin
    if (flags.silent)                          streakNext = '0;
    else if (!flags.agree)                     streakNext = SW'(1);
    else if (streak == RUN_FULL)               streakNext = RUN_FULL;
    else                                       streakNext = streak + 1'b1;
    lockNext = (streakNext == RUN_FULL);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      streak  <= '0;
      lockReg <= 1'b0;
    end else if (gateEnd) begin
      streak  <= streakNext;
      lockReg <= lockNext;
    end
  end

  assign strobe.gateEnd   = gateEnd;
  assign strobe.selUpdate = gateEnd & lockNext;
  assign lockOut          = lockReg;
endmodule

// File: rtl/rate_path_selector.sv
module rate_path_selector
  import ratesel_pkg::*;
#(
  parameter int GATE_CYCLES = 491520,
  parameter int RATE_W      = 16,
  parameter int HYST_COUNTS = 5,
  parameter int LOCK_RUN    = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lrckIn,
  input  logic [RATE_W-1:0] thresholdIn,
  output logic [RATE_W-1:0] rateOut,
  output logic              lockOut,
  output logic              selectX2Out
);
  ctrlStrobe_t strobe;
  measFlags_t  flags;

  ratesel_datapath #(
    .RATE_W     (RATE_W),
    .HYST_COUNTS(HYST_COUNTS)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .lrckIn     (lrckIn),
    .thresholdIn(thresholdIn),
    .strobe     (strobe),
    .flags      (flags),
    .rateOut    (rateOut),
    .selectX2Out(selectX2Out)
  );

  ratesel_control #(
    .GATE_CYCLES(GATE_CYCLES),
    .LOCK_RUN   (LOCK_RUN)
  ) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .flags  (flags),
    .strobe (strobe),
    .lockOut(lockOut)
  );
endmodule

// File: rtl/ratesel_checker.sv
module ratesel_checker #(
  parameter int RATE_W      = 16,
  parameter int HYST_COUNTS = 5
) (
  input logic              clk,
  input logic              rstN,
  input logic [RATE_W-1:0] thresholdIn,
  input logic [RATE_W-1:0] rateOut,
  input logic              lockOut,
  input logic              selectX2Out
);
  localparam logic [RATE_W:0] HW = (RATE_W+1)'(HYST_COUNTS);

  logic [RATE_W:0] rateW, prevRateW, prevThrW;
  assign rateW = {1'b0, rateOut};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevRateW <= '0;
      prevThrW  <= '0;
    end else begin
      prevRateW <= {1'b0, rateOut};
      prevThrW  <= {1'b0, thresholdIn};
    end
  end

  assert_lock_on_agree_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lockOut) |-> ((rateW >= prevRateW) ? (rateW - prevRateW) : (prevRateW - rateW)) <= 1);

  assert_silent_unlocked_R5: assert property (@(posedge clk) disable iff (!rstN)
    (rateOut == '0) |-> !lockOut);

  assert_direct_above_band_R6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(selectX2Out) |-> (rateW > prevThrW + HW));

  assert_x2_below_band_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(selectX2Out) |-> (rateW + HW < prevThrW));

  assert_select_frozen_R9: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(selectX2Out) |-> lockOut);
endmodule

bind rate_path_selector ratesel_checker #(
  .RATE_W     (RATE_W),
  .HYST_COUNTS(HYST_COUNTS)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .thresholdIn(thresholdIn),
  .rateOut    (rateOut),
  .lockOut    (lockOut),
  .selectX2Out(selectX2Out)
);

// File: tb/rate_path_selector_bench.sv
`timescale 1ns/1ps
module rate_path_selector_bench;
  localparam int G    = 1200;
  localparam int HYST = 5;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        lrck = 1'b0;
  logic [15:0] thr = 16'd100;
  logic [15:0] rateOut;
  logic        lockOut, selOut;

  int total = 0;
  int bad   = 0;
  int per   = 0;
  int model = 1;
  bit done  = 0;

  always #2.5 clk = ~clk;

  rate_path_selector #(
    .GATE_CYCLES(G),
    .RATE_W     (16),
    .HYST_COUNTS(HYST),
    .LOCK_RUN   (3)
  ) u_rate_path_selector (
    .clk        (clk),
    .rstN       (rstN),
    .lrckIn     (lrck),
    .thresholdIn(thr),
    .rateOut    (rateOut),
    .lockOut    (lockOut),
    .selectX2Out(selOut)
  );

  // word clock generator, period in reference cycles (0 = stopped)
  initial begin
    forever begin
      if (per == 0) @(posedge clk);
      else begin
        repeat (per / 2) @(posedge clk);
        lrck <= 1'b1;
        repeat (per / 2) @(posedge clk);
        lrck <= 1'b0;
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d (per=%0d thr=%0d)", req, act, exp, per, thr);
    end
  endtask

  task automatic waitG(input int n);
    repeat (n * G) @(posedge clk);
    @(negedge clk);
  endtask

  // select model, used only while locked
  function automatic string applyModel(input int r, input int t);
    if (r > t + HYST) begin model = 0; return "R6"; end
    if (r + HYST < t) begin model = 1; return "R7"; end
    return "R8";
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int periods[7] = '{6, 10, 12, 16, 8, 20, 24};
    string tag;
    repeat (5) @(negedge clk);
    chk("R1 rate", rateOut, 0);
    chk("R1 lock", lockOut, 0);
    chk("R1 sel", selOut, 1);
    @(negedge clk);
    rstN = 1'b1;
    per  = 12;
    repeat (G / 2) @(posedge clk);
    @(negedge clk);
    waitG(2);
    chk("R3 no lock after two gates", lockOut, 0);
    chk("R9 sel frozen unlocked", selOut, 1);
    waitG(1);
    chk("R3 lock after three gates", lockOut, 1);
    chk("R2 rate 100", rateOut, 100);
    chk("R8 in band hold", selOut, 1);

    foreach (periods[i]) begin
      per = periods[i];
      waitG(2);
      chk("R4 lock lost on jump", lockOut, 0);
      chk("R9 sel held while unlocked", selOut, model);
      waitG(3);
      chk("R3 relock", lockOut, 1);
      chk("R2 rate count", rateOut, G / periods[i]);
      tag = applyModel(G / periods[i], 100);
      chk(tag, selOut, model);
    end

    per = 12;
    waitG(5);
    chk("R2 rate back to 100", rateOut, 100);
    tag = applyModel(100, 100);
    chk(tag, selOut, model);

    for (int t = 84; t <= 116; t += 2) begin
      thr = 16'(t);
      waitG(1);
      tag = applyModel(100, t);
      chk(tag, selOut, model);
    end
    for (int t = 116; t >= 84; t -= 2) begin
      thr = 16'(t);
      waitG(1);
      tag = applyModel(100, t);
      chk(tag, selOut, model);
    end

    per = 0;
    waitG(2);
    chk("R5 rate zero when silent", rateOut, 0);
    chk("R5 unlocked when silent", lockOut, 0);
    chk("R9 sel held when silent", selOut, model);

    per = 6;
    waitG(5);
    chk("R3 relock after silence", lockOut, 1);
    chk("R2 rate 200", rateOut, 200);
    tag = applyModel(200, 84);
    chk(tag, selOut, model);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule